// File: doc/BRIEF.md
# Broadcast Label Packet Hamming Acquisition

This block receives the bytes of a teletext broadcast service data packet that carries the programme label (format 2), one byte per strobe, together with the position of that byte within the packet. Each byte in positions 13 to 25 is protected by a Hamming 8/4 code. The block decodes each byte to its four message bits, repairs any single flipped bit, and records whether a byte was beyond repair. The recovered nibbles collect in a holding register.

When the line-end strobe arrives, the holding register is committed to the transfer register only if all thirteen positions arrived since the previous line end, none of them held an uncorrectable error, and the host is not reading at that moment. A successful commit drives the active-low data-valid output low for one cycle. A rejected packet leaves the transfer register exactly as it was. The line-end strobe always clears the collected state, so the next packet starts empty.

Top module: `pdc_ham_acq`

## Requirements
- R1: `byte_data[i]` is transmission bit i, and bit 0 is sent first. For a byte with no error, the message nibble is {bit7, bit5, bit3, bit1}, with bit1 as the nibble LSB. The protection bits sit at positions 0, 2, 4 and 6. The four parity checks use odd parity: {0,1,5,7}, {1,2,3,7}, {3,4,5,7} and all eight bits.
- R2: A byte with exactly one flipped bit, at any of the 8 positions, yields the same nibble as the error-free byte, and the packet still commits.
- R3: A byte with exactly two flipped bits is uncorrectable. The packet it belongs to is not committed, `dav_n` stays high, and `xfer_q` keeps its previous value.
- R4: `xfer_q[7:0]` is {4'b1111, nibble of byte 13}. For k = 1..6, `xfer_q[8k+7:8k]` is {nibble of byte 12+2k+1, nibble of byte 12+2k}.
- R5: A commit updates `xfer_q` and drives `dav_n` low in the cycle after the line-end strobe. `dav_n` returns high one cycle later and is high at all other times.
- R6: A commit requires every position from 13 to 25 to have been received since the previous line end. If any position is missing, nothing is committed.
- R7: If `host_busy` is high in the line-end cycle, the packet is not committed and `xfer_q` is unchanged.
- R8: After reset, `xfer_q` is all zeros and `dav_n` is high.
- R9: Bytes whose index lies outside 13..25 have no effect on `xfer_q` or on whether a commit happens.
- R10: The line-end strobe clears the record of received positions and of errors. Bytes from an earlier line do not count toward the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Strobe: `byte_data` and `byte_idx` are valid |
| byte_idx | input | 6 | Position of the byte within the packet |
| byte_data | input | 8 | Received byte, bit i = transmission bit i |
| line_end | input | 1 | Strobe marking the end of the packet line |
| host_busy | input | 1 | Host is reading the transfer register |
| xfer_q | output | 56 | Transfer register, 7 packed bytes |
| dav_n | output | 1 | Active-low data-valid, low for one cycle per commit |

## Verification
The bench encodes every nibble and then flips each of the eight bit positions in turn. A decoder that used the wrong parity group, or flipped the wrong data bit, would return a nibble that differs from the encoded one. It also flips every one of the 28 bit pairs inside a single byte. A design that treated a double error as correctable would commit a wrong packet and pulse `dav_n`.

The bench withholds each position in turn to catch a design that commits an incomplete line. It raises `host_busy` at line end to catch a design that ignores the host. It sends out-of-range indices to catch a design that aliases them into the packet. It splits one packet across two line ends to catch a design that does not clear its state at line end.

// File: rtl/pdc_ham_pkg.sv
package pdc_ham_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  typedef logic [NIB_W-1:0]  nibble_t;
  typedef logic [BYTE_W-1:0] code_t;
  localparam nibble_t FILL_NIB = '1;
endpackage

// File: rtl/ham84_dec.sv
module ham84_dec
  import pdc_ham_pkg::*;
(
  input  code_t   code,
  output nibble_t nib,
  output logic    uncorr
);
  logic ok_a, ok_b, ok_c, ok_all;
  logic f_a, f_b, f_c;

  always_comb begin
    // odd parity: each group must xor to one
    ok_a   = ^{code[0], code[1], code[5], code[7]};
    ok_b   = ^{code[1], code[2], code[3], code[7]};
    ok_c   = ^{code[3], code[4], code[5], code[7]};
    ok_all = ^code;
    f_a = ~ok_a;
    f_b = ~ok_b;
    f_c = ~ok_c;
    // two flips keep overall parity but leave a non-zero syndrome
    uncorr = ok_all & (f_a | f_b | f_c);
    nib[0] = code[1] ^ ( f_a &  f_b & ~f_c);
    nib[1] = code[3] ^ (~f_a &  f_b &  f_c);
    nib[2] = code[5] ^ ( f_a & ~f_b &  f_c);
    nib[3] = code[7] ^ ( f_a &  f_b &  f_c);
  end
endmodule

// File: rtl/pkt_collect.sv
module pkt_collect
  import pdc_ham_pkg::*;
#(
  parameter int FIRST_IDX = 13,
  parameter int NUM_BYTES = 13,
  parameter int IDX_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     byte_valid,
  input  logic [IDX_W-1:0]         byte_idx,
  input  nibble_t                  nib,
  input  logic                     uncorr,
  input  logic                     line_end,
  output logic [NUM_BYTES*NIB_W-1:0] hold_q,
  output logic                     pkt_ok,
  output logic                     any_seen
);
  localparam int LAST_IDX = FIRST_IDX + NUM_BYTES - 1;

  logic [NUM_BYTES-1:0] seen_q;
  logic                 bad_q;
  logic                 in_range;
  logic [IDX_W-1:0]     slot;

  assign in_range = (byte_idx >= IDX_W'(FIRST_IDX)) && (byte_idx <= IDX_W'(LAST_IDX));
  assign slot     = byte_idx - IDX_W'(FIRST_IDX);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        seen_q[i] <= 1'b0;
        hold_q[i*NIB_W +: NIB_W] <= '0;
      end else if (line_end) begin
        seen_q[i] <= 1'b0;
      end else if (byte_valid && in_range && slot == IDX_W'(i)) begin
        seen_q[i] <= 1'b1;
        hold_q[i*NIB_W +: NIB_W] <= nib;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || line_end)
      bad_q <= 1'b0;
    else if (byte_valid && in_range && uncorr)
      bad_q <= 1'b1;
  end

  assign pkt_ok   = (&seen_q) & ~bad_q;
  assign any_seen = |seen_q;
endmodule

// File: rtl/xfer_commit.sv
module xfer_commit
  import pdc_ham_pkg::*;
#(
  parameter int NUM_BYTES = 13,
  parameter int OUT_BYTES = 7
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         line_end,
  input  logic                         host_busy,
  input  logic                         pkt_ok,
  input  logic [NUM_BYTES*NIB_W-1:0]   hold_q,
  output logic [OUT_BYTES*BYTE_W-1:0]  xfer_q,
  output logic                         dav_n
);
  logic [OUT_BYTES*BYTE_W-1:0] packed_w;
  logic                        commit;

  assign packed_w[BYTE_W-1:0] = {FILL_NIB, hold_q[NIB_W-1:0]};
  for (genvar k = 1; k < OUT_BYTES; k++) begin : g_pack
    assign packed_w[k*BYTE_W +: BYTE_W] =
      {hold_q[(2*k)*NIB_W +: NIB_W], hold_q[(2*k-1)*NIB_W +: NIB_W]};
  end

  assign commit = line_end & pkt_ok & ~host_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= '0;
      dav_n  <= 1'b1;
    end else begin
      dav_n <= ~commit;
      if (commit) xfer_q <= packed_w;
    end
  end
endmodule

// File: rtl/pdc_ham_acq.sv
module pdc_ham_acq
  import pdc_ham_pkg::*;
#(
  parameter int FIRST_IDX = 13,
  parameter int NUM_BYTES = 13,
  parameter int IDX_W     = 6,
  localparam int OUT_BYTES = 1 + (NUM_BYTES - 1) / 2,
  localparam int OUT_W     = OUT_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [7:0]       byte_data,
  input  logic             line_end,
  input  logic             host_busy,
  output logic [OUT_W-1:0] xfer_q,
  output logic             dav_n
);
  nibble_t                    dec_nib;
  logic                       dec_uncorr;
  logic [NUM_BYTES*NIB_W-1:0] hold_q;
  logic                       pkt_ok;
  logic                       any_seen;

  ham84_dec u_dec (
    .code   (byte_data),
    .nib    (dec_nib),
    .uncorr (dec_uncorr)
  );

  pkt_collect #(
    .FIRST_IDX (FIRST_IDX),
    .NUM_BYTES (NUM_BYTES),
    .IDX_W     (IDX_W)
  ) u_collect (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_idx   (byte_idx),
    .nib        (dec_nib),
    .uncorr     (dec_uncorr),
    .line_end   (line_end),
    .hold_q     (hold_q),
    .pkt_ok     (pkt_ok),
    .any_seen   (any_seen)
  );

  xfer_commit #(
    .NUM_BYTES (NUM_BYTES),
    .OUT_BYTES (OUT_BYTES)
  ) u_commit (
    .clk       (clk),
    .rst       (rst),
    .line_end  (line_end),
    .host_busy (host_busy),
    .pkt_ok    (pkt_ok),
    .hold_q    (hold_q),
    .xfer_q    (xfer_q),
    .dav_n     (dav_n)
  );
endmodule

// File: rtl/pdc_ham_acq_chk.sv
module pdc_ham_acq_chk #(
  parameter int OUT_W = 56
) (
  input logic             clk,
  input logic             rst,
  input logic             line_end,
  input logic             host_busy,
  input logic             pkt_ok,
  input logic             any_seen,
  input logic [OUT_W-1:0] xfer_q,
  input logic             dav_n
);
  assert_dav_after_end_R5: assert property (@(posedge clk) disable iff (rst)
    !dav_n |-> $past(line_end));

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (line_end && host_busy) |=> dav_n);

  assert_whole_packet_R6: assert property (@(posedge clk) disable iff (rst)
    (line_end && !pkt_ok) |=> dav_n);

  assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (rst)
    dav_n |-> $stable(xfer_q));

  assert_line_clear_R10: assert property (@(posedge clk) disable iff (rst)
    line_end |=> !any_seen);
endmodule

bind pdc_ham_acq pdc_ham_acq_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_end  (line_end),
  .host_busy (host_busy),
  .pkt_ok    (pkt_ok),
  .any_seen  (any_seen),
  .xfer_q    (xfer_q),
  .dav_n     (dav_n)
);

// File: tb/pdc_ham_acq_tb.sv
module pdc_ham_acq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_valid = 1'b0;
  logic [5:0]  byte_idx = '0;
  logic [7:0]  byte_data = '0;
  logic        line_end = 1'b0;
  logic        host_busy = 1'b0;
  logic [55:0] xfer_q;
  logic        dav_n;

  int checks = 0;
  int errors = 0;
  logic [3:0]  nb [13];
  logic [7:0]  cw [13];
  logic [55:0] exp_x = '0;

  always #10 clk = ~clk;

  pdc_ham_acq u_dut (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_idx(byte_idx),
    .byte_data(byte_data), .line_end(line_end), .host_busy(host_busy),
    .xfer_q(xfer_q), .dav_n(dav_n)
  );

  function automatic logic [7:0] enc(input logic [3:0] d);
    logic p0, p2, p4, p6;
    p0 = ~(d[0] ^ d[2] ^ d[3]);
    p2 = ~(d[0] ^ d[1] ^ d[3]);
    p4 = ~(d[1] ^ d[2] ^ d[3]);
    p6 = ~(p0 ^ d[0] ^ p2 ^ d[1] ^ p4 ^ d[2] ^ d[3]);
    return {d[3], p6, d[2], p4, d[1], p2, d[0], p0};
  endfunction

  function automatic logic [55:0] pack_exp();
    logic [55:0] r;
    r[7:0] = {4'hF, nb[0]};
    for (int k = 1; k < 7; k++) r[8*k +: 8] = {nb[2*k], nb[2*k-1]};
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic [5:0] idx, input logic [7:0] d);
    @(negedge clk);
    byte_valid = 1'b1; byte_idx = idx; byte_data = d;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_set(input int skip);
    for (int i = 0; i < 13; i++)
      if (i != skip) send(6'(13 + i), cw[i]);
  endtask

  task automatic close_line(input logic busy, input logic expect_commit, input string req);
    @(negedge clk);
    line_end = 1'b1; host_busy = busy;
    @(negedge clk);
    line_end = 1'b0; host_busy = 1'b0;
    if (expect_commit) exp_x = pack_exp();
    chk(dav_n == !expect_commit, req, 64'(dav_n), 64'(!expect_commit));
    chk(xfer_q == exp_x, req, 64'(xfer_q), 64'(exp_x));
    @(negedge clk);
    chk(dav_n == 1'b1, "R5 dav_n back high", 64'(dav_n), 64'd1);
  endtask

  task automatic load_clean(input int base);
    for (int i = 0; i < 13; i++) begin
      nb[i] = 4'(base + 3 * i);
      cw[i] = enc(nb[i]);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dav_n == 1'b1, "R8 reset dav_n", 64'(dav_n), 64'd1);
    chk(xfer_q == '0, "R8 reset xfer_q", 64'(xfer_q), 64'd0);

    // R1 / R2 / R4: every nibble, clean and with each single-bit error
    for (int e = -1; e < 8; e++) begin
      for (int n = 0; n < 16; n++) begin
        load_clean(n);
        if (e >= 0) for (int i = 0; i < 13; i++) cw[i][e] = ~cw[i][e];
        send_set(-1);
        close_line(1'b0, 1'b1, (e < 0) ? "R1 R4 clean decode" : "R2 single correction");
      end
    end

    // R3: every double-error pair in one byte blocks the packet
    for (int a = 0; a < 8; a++) begin
      for (int b = a + 1; b < 8; b++) begin
        load_clean(a * 8 + b);
        cw[(a + b) % 13][a] = ~cw[(a + b) % 13][a];
        cw[(a + b) % 13][b] = ~cw[(a + b) % 13][b];
        send_set(-1);
        close_line(1'b0, 1'b0, "R3 double error rejected");
      end
    end

    // R6: each missing position prevents commit
    for (int s = 0; s < 13; s++) begin
      load_clean(s + 5);
      send_set(s);
      close_line(1'b0, 1'b0, "R6 missing byte");
    end

    // R7: host busy blocks, next clean packet commits
    load_clean(9);
    send_set(-1);
    close_line(1'b1, 1'b0, "R7 busy blocks");
    send_set(-1);
    close_line(1'b0, 1'b1, "R7 commit after busy");

    // R9: out-of-range indices ignored
    load_clean(2);
    send(6'd12, 8'h00);
    send_set(-1);
    send(6'd26, 8'hFF);
    send(6'd0, 8'h55);
    send(6'd63, 8'hAA);
    close_line(1'b0, 1'b1, "R9 out-of-range ignored");
    send(6'd12, enc(4'h7));
    send(6'd26, enc(4'h7));
    close_line(1'b0, 1'b0, "R9 out-of-range alone");

    // R10: packet split across line ends does not commit
    load_clean(11);
    for (int i = 0; i < 6; i++) send(6'(13 + i), cw[i]);
    close_line(1'b0, 1'b0, "R10 partial first half");
    for (int i = 6; i < 13; i++) send(6'(13 + i), cw[i]);
    close_line(1'b0, 1'b0, "R10 state cleared");

    summary();
  end
endmodule